// File: doc/BRIEF.md
# ALU Operand Bypass Selector

This block sits beside the execute stage of a five-stage integer pipeline and picks where each of the two ALU operands comes from. It compares the execute-stage source register numbers with the destination register numbers of the two older instructions still in flight. One older instruction is in the memory stage and the other is in write-back. For each operand it drives a 2-bit select that steers an external multiplexer.

The first operand carries the rs number. For loads and stores this is the base register. It drives the upper ALU input. The second operand carries the rt number and drives the lower ALU input. The block has no state and no clock. The pipeline registers around it supply every input, and its outputs settle within the same cycle.

A result is worth bypassing only when its producer really writes a register other than register 0. When both older instructions target the matching register, the younger producer holds the newer value and wins.

Top module: `alu_bypass_select`

## Requirements
- R1: While `ex_valid_i` is 0, both `sel_a_o` and `sel_b_o` are 2'b00, whatever the other inputs hold.
- R2: With a valid execute instruction, `sel_a_o` is 2'b01 when `mem_we_i` is 1, `mem_dst_i` equals `ex_src_a_i`, and that number is not 0.
- R3: `sel_a_o` is 2'b10 when the memory-stage producer does not match under R2 but `wb_we_i` is 1, `wb_dst_i` equals `ex_src_a_i`, and that number is not 0.
- R4: When both producers write the register an operand reads, the select is 2'b01, because the memory-stage result takes priority.
- R5: A source number of 0 never forwards: the select stays 2'b00 even when a producer writes register 0.
- R6: A producer whose write enable is 0 is ignored. If the other producer matches, its code is used; otherwise the code is 2'b00.
- R7: `sel_b_o` follows the rules of R2 through R6 using `ex_src_b_i`, and it is independent of operand A.
- R8: With no qualifying match the select is 2'b00 (register-file value), and the code 2'b11 is never driven on either select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_valid_i | input | 1 | Execute stage holds a real instruction |
| ex_src_a_i | input | 5 | Execute-stage first source register (rs / base) |
| ex_src_b_i | input | 5 | Execute-stage second source register (rt) |
| mem_dst_i | input | 5 | Destination register of the memory-stage instruction |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| wb_dst_i | input | 5 | Destination register of the write-back instruction |
| wb_we_i | input | 1 | Write-back instruction writes a register |
| sel_a_o | output | 2 | Upper ALU operand select: 00 register file, 01 memory stage, 10 write-back |
| sel_b_o | output | 2 | Lower ALU operand select, same encoding |

## Verification
The checks assume that every input is a settled 2-state value once it is sampled. They do not rely on any link between the write enables and the destination numbers, so a producer may claim register 0 or disable its write while still holding a matching number. The stimulus changes all inputs together, away from the clock edge, and then waits before it samples. It deliberately builds illegal-looking pipeline contents, such as writes to register 0 and disabled writers that match, so that each gating rule is exercised at the outputs.

// File: rtl/alu_bypass_pkg.sv
// Shared encoding of the operand source select.
// Assumes the consuming multiplexer decodes the code 11 as unused.
package alu_bypass_pkg;

    localparam int unsigned REG_AW = 5;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_MEM     = 2'b01,
        SRC_WB      = 2'b10
    } src_sel_t;

endpackage

// File: rtl/bypass_hit.sv
// Decides whether one older producer supplies the register an operand reads.
// Assumes register 0 is hard-wired and is never a forwarding target.
module bypass_hit #(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic          we_i,
    output logic          hit_o
);

    localparam logic [AW-1:0] ZERO_REG = '0;

    // Compare numbers, qualified by the write enable and the zero register.
    always_comb begin
        hit_o = we_i && (dst_i == src_i) && (src_i != ZERO_REG);
    end

endmodule

// File: rtl/bypass_operand.sv
// Produces the select for a single ALU operand from the two producer hits.
// Assumes the memory-stage producer is younger than the write-back one.
module bypass_operand
    import alu_bypass_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic          valid_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] mem_dst_i,
    input  logic          mem_we_i,
    input  logic [AW-1:0] wb_dst_i,
    input  logic          wb_we_i,
    output src_sel_t      sel_o
);

    logic near_hit;
    logic far_hit;

    bypass_hit #(.AW(AW)) near_cmp_i (
        .src_i (src_i),
        .dst_i (mem_dst_i),
        .we_i  (mem_we_i),
        .hit_o (near_hit)
    );

    bypass_hit #(.AW(AW)) far_cmp_i (
        .src_i (src_i),
        .dst_i (wb_dst_i),
        .we_i  (wb_we_i),
        .hit_o (far_hit)
    );

    // Priority pick: the nearer producer first, then the older one, else the register file.
    always_comb begin
        if (!valid_i)      sel_o = SRC_REGFILE;
        else if (near_hit) sel_o = SRC_MEM;
        else if (far_hit)  sel_o = SRC_WB;
        else               sel_o = SRC_REGFILE;
    end

endmodule

// File: rtl/alu_bypass_select.sv
// Top of the operand bypass selector: one selector per ALU operand.
// Assumes all inputs come straight from pipeline registers; purely combinational.
module alu_bypass_select
    import alu_bypass_pkg::*;
#(
    parameter int unsigned AW     = REG_AW,
    parameter int unsigned NUM_OP = 2
) (
    input  logic          ex_valid_i,
    input  logic [AW-1:0] ex_src_a_i,
    input  logic [AW-1:0] ex_src_b_i,
    input  logic [AW-1:0] mem_dst_i,
    input  logic          mem_we_i,
    input  logic [AW-1:0] wb_dst_i,
    input  logic          wb_we_i,
    output logic [1:0]    sel_a_o,
    output logic [1:0]    sel_b_o
);

    logic [AW-1:0] op_src [NUM_OP];
    src_sel_t      op_sel [NUM_OP];

    // Gather the operand source numbers into an indexable array.
    always_comb begin
        op_src[0] = ex_src_a_i;
        op_src[1] = ex_src_b_i;
    end

    for (genvar g = 0; g < NUM_OP; g++) begin : g_op
        bypass_operand #(.AW(AW)) op_i (
            .valid_i   (ex_valid_i),
            .src_i     (op_src[g]),
            .mem_dst_i (mem_dst_i),
            .mem_we_i  (mem_we_i),
            .wb_dst_i  (wb_dst_i),
            .wb_we_i   (wb_we_i),
            .sel_o     (op_sel[g])
        );
    end

    // Drive the per-operand selects onto the output ports.
    always_comb begin
        sel_a_o = op_sel[0];
        sel_b_o = op_sel[1];
    end

endmodule

// File: rtl/alu_bypass_select_chk.sv
// Checker for alu_bypass_select: relates the output selects to the producer inputs.
// Assumes 2-state settled inputs; uses immediate assertions since the block has no clock.
module alu_bypass_select_chk #(
    parameter int unsigned AW = 5
) (
    input logic          ex_valid_i,
    input logic [AW-1:0] ex_src_a_i,
    input logic [AW-1:0] ex_src_b_i,
    input logic [AW-1:0] mem_dst_i,
    input logic          mem_we_i,
    input logic [AW-1:0] wb_dst_i,
    input logic          wb_we_i,
    input logic [1:0]    sel_a_o,
    input logic [1:0]    sel_b_o
);

    // Evaluate every rule whenever an input or output changes.
    always_comb begin
        assert_idle_zero_R1: assert (ex_valid_i || (sel_a_o == 2'b00 && sel_b_o == 2'b00))
            else $error("idle execute stage produced a non-zero select");
        assert_near_src_R2: assert (sel_a_o != 2'b01 || (mem_we_i && mem_dst_i == ex_src_a_i))
            else $error("operand A near select without a matching writer");
        assert_far_src_R3: assert (sel_a_o != 2'b10 || (wb_we_i && wb_dst_i == ex_src_a_i
                                   && !(mem_we_i && mem_dst_i == ex_src_a_i)))
            else $error("operand A far select without a sole far match");
        assert_near_prio_R4: assert (!(ex_valid_i && mem_we_i && mem_dst_i == ex_src_a_i
                                     && ex_src_a_i != '0) || sel_a_o == 2'b01)
            else $error("operand A missed the nearer producer");
        assert_zero_reg_R5: assert ((ex_src_a_i != '0 || sel_a_o == 2'b00)
                                    && (ex_src_b_i != '0 || sel_b_o == 2'b00))
            else $error("register 0 was forwarded");
        assert_we_gate_R6: assert ((sel_a_o != 2'b10 || wb_we_i) && (sel_b_o != 2'b10 || wb_we_i))
            else $error("forwarded from a non-writing producer");
        assert_op_b_R7: assert ((sel_b_o != 2'b01 || (mem_we_i && mem_dst_i == ex_src_b_i))
                                && (sel_b_o != 2'b10 || (wb_we_i && wb_dst_i == ex_src_b_i)))
            else $error("operand B select does not follow its own source");
        assert_code_legal_R8: assert (sel_a_o != 2'b11 && sel_b_o != 2'b11)
            else $error("reserved select code driven");
    end

endmodule

bind alu_bypass_select alu_bypass_select_chk #(.AW(AW)) chk_i (
    .ex_valid_i (ex_valid_i),
    .ex_src_a_i (ex_src_a_i),
    .ex_src_b_i (ex_src_b_i),
    .mem_dst_i  (mem_dst_i),
    .mem_we_i   (mem_we_i),
    .wb_dst_i   (wb_dst_i),
    .wb_we_i    (wb_we_i),
    .sel_a_o    (sel_a_o),
    .sel_b_o    (sel_b_o)
);

// File: tb/alu_bypass_select_tb_top.sv
`timescale 1ns/1ps
// Bench for alu_bypass_select: a vector table followed by directed corner sweeps.
module alu_bypass_select_tb_top;

    logic       clk;
    logic       rst_n;
    logic       ex_valid;
    logic [4:0] src_a, src_b, mem_dst, wb_dst;
    logic       mem_we, wb_we;
    logic [1:0] sel_a, sel_b;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 0;

    // Vector layout: valid, src_a, src_b, mem_dst, mem_we, wb_dst, wb_we, exp_a, exp_b
    localparam int NV = 12;
    localparam logic [26:0] VECS [0:NV-1] = '{
        {1'b1, 5'd5,  5'd6,  5'd5,  1'b1, 5'd9,  1'b1, 2'b01, 2'b00}, // R2
        {1'b1, 5'd5,  5'd6,  5'd9,  1'b1, 5'd6,  1'b1, 2'b00, 2'b10}, // R7
        {1'b1, 5'd7,  5'd7,  5'd7,  1'b1, 5'd7,  1'b1, 2'b01, 2'b01}, // R4
        {1'b1, 5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R5
        {1'b1, 5'd4,  5'd8,  5'd4,  1'b0, 5'd8,  1'b0, 2'b00, 2'b00}, // R6
        {1'b0, 5'd4,  5'd8,  5'd4,  1'b1, 5'd8,  1'b1, 2'b00, 2'b00}, // R1
        {1'b1, 5'd3,  5'd3,  5'd12, 1'b1, 5'd3,  1'b1, 2'b10, 2'b10}, // R3
        {1'b1, 5'd31, 5'd2,  5'd31, 1'b1, 5'd2,  1'b1, 2'b01, 2'b10}, // R7
        {1'b1, 5'd10, 5'd11, 5'd12, 1'b1, 5'd13, 1'b1, 2'b00, 2'b00}, // R8
        {1'b1, 5'd0,  5'd5,  5'd0,  1'b1, 5'd5,  1'b1, 2'b00, 2'b10}, // R5
        {1'b1, 5'd6,  5'd5,  5'd6,  1'b0, 5'd6,  1'b1, 2'b10, 2'b00}, // R6
        {1'b1, 5'd9,  5'd9,  5'd9,  1'b1, 5'd9,  1'b0, 2'b01, 2'b01}  // R2
    };

    // Requirement tag for each table row.
    function automatic string vec_req(input int i);
        case (i)
            0, 11:  return "R2";
            1, 7:   return "R7";
            2:      return "R4";
            3, 9:   return "R5";
            4, 10:  return "R6";
            5:      return "R1";
            6:      return "R3";
            default: return "R8";
        endcase
    endfunction

    alu_bypass_select dut_i (
        .ex_valid_i (ex_valid),
        .ex_src_a_i (src_a),
        .ex_src_b_i (src_b),
        .mem_dst_i  (mem_dst),
        .mem_we_i   (mem_we),
        .wb_dst_i   (wb_dst),
        .wb_we_i    (wb_we),
        .sel_a_o    (sel_a),
        .sel_b_o    (sel_b)
    );

    // 200 MHz bench clock.
    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Compare one select against its expected code.
    task automatic check(input string req, input string what, input logic [1:0] act,
                         input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Apply one set of pipeline contents at the falling edge.
    task automatic drive(input logic v, input logic [4:0] a, input logic [4:0] b,
                         input logic [4:0] md, input logic mw, input logic [4:0] wd,
                         input logic ww);
        @(negedge clk);
        ex_valid = v; src_a = a; src_b = b;
        mem_dst = md; mem_we = mw; wb_dst = wd; wb_we = ww;
        #1;
    endtask

    // Stimulus: reset check, vector table, then directed sweeps.
    initial begin
        rst_n = 1'b0;
        ex_valid = 1'b0; src_a = 5'd1; src_b = 5'd1;
        mem_dst = 5'd1; mem_we = 1'b1; wb_dst = 5'd1; wb_we = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check("R1", "reset sel_a", sel_a, 2'b00);
        check("R1", "reset sel_b", sel_b, 2'b00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i][26], VECS[i][25:21], VECS[i][20:16], VECS[i][15:11],
                  VECS[i][10], VECS[i][9:5], VECS[i][4]);
            check(vec_req(i), $sformatf("vector %0d sel_a", i), sel_a, VECS[i][3:2]);
            check(vec_req(i), $sformatf("vector %0d sel_b", i), sel_b, VECS[i][1:0]);
        end

        // R2 and R5 sweep: the near producer matches operand A for every register number.
        for (int r = 0; r < 32; r++) begin
            drive(1'b1, 5'(r), 5'((r + 1) % 32), 5'(r), 1'b1, 5'((r + 3) % 32), 1'b1);
            check(r == 0 ? "R5" : "R2", $sformatf("near sweep reg %0d", r), sel_a,
                  r == 0 ? 2'b00 : 2'b01);
        end

        // R3 and R7 sweep: only the far producer matches operand B.
        for (int r = 0; r < 32; r++) begin
            drive(1'b1, 5'((r + 1) % 32), 5'(r), 5'((r + 2) % 32), 1'b1, 5'(r), 1'b1);
            check(r == 0 ? "R5" : "R7", $sformatf("far sweep reg %0d", r), sel_b,
                  r == 0 ? 2'b00 : 2'b10);
        end

        // R4 on operand B: both producers write it, with the near write disabled and then enabled.
        drive(1'b1, 5'd2, 5'd20, 5'd20, 1'b0, 5'd20, 1'b1);
        check("R6", "B near disabled", sel_b, 2'b10);
        drive(1'b1, 5'd2, 5'd20, 5'd20, 1'b1, 5'd20, 1'b1);
        check("R4", "B both match", sel_b, 2'b01);
        check("R8", "A no match", sel_a, 2'b00);

        // R1 again after activity: dropping valid clears selects with full matches present.
        drive(1'b0, 5'd20, 5'd20, 5'd20, 1'b1, 5'd20, 1'b1);
        check("R1", "idle sel_a", sel_a, 2'b00);
        check("R1", "idle sel_b", sel_b, 2'b00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #50000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule